// File: doc/BRIEF.md
# Video Blank, Sync and Pedestal Level Encoder

This block sits between a pixel pipeline and three video DACs. For each colour channel it merges the 8-bit pixel code with the active-low blank and composite-sync timing inputs and a set of static control bits. It produces one digital level code per channel. That code already contains the sync tip, the blanking level, an optional set-up pedestal and the scaled video span. Levels are counted in eighths of an IRE unit: the sync step is 320, the pedestal step is 60 and the full video span is 740. The largest code is therefore 1120. Converting the code to a real current is left to the analog stage.

Sync insertion is enabled separately for each channel. A channel without sync keeps its blanking level at zero. Two flags tell the complementary output stage when blanking or sync must also be shown on the inverted outputs. A sync-out pin can carry a copy of composite sync, aligned to the colour outputs. Timing inputs and control bits pass through the same two register stages as the pixel codes. The whole result therefore appears two clock edges after the inputs are sampled.

Top module: `venc_level_encoder`

## Requirements
- R1: While `rst` is high and in the first output after it, all three level outputs, both inverted-output flags and `sync_out` are 0.
- R2: Every output reflects the inputs sampled exactly two rising clock edges earlier. After one edge, the output still shows the previous inputs.
- R3: With `blank_n`=1, a channel's level is base + ped + floor(code*740/255). Here base is 320 if that channel's sync enable is 1 and 0 otherwise, and ped is 60 if `pedestal_en`=1 and 0 otherwise.
- R4: With `blank_n`=0 and either `csync_n`=1 or the channel's sync enable at 0, the level is base (320 or 0). No pedestal is added and the pixel code has no effect.
- R5: With `blank_n`=0, `csync_n`=0 and the channel's sync enable at 1, the level is 0 (sync tip), regardless of the pixel code and the pedestal.
- R6: With `blank_n`=1, `csync_n`=0 has no effect: the level is the R3 value and `inv_sync_flag` stays 0.
- R7: `sync_chan_en` bit 2 enables sync for red, bit 1 for green and bit 0 for blue. Each bit affects only its own channel.
- R8: `inv_blank_flag` = `inv_blank_en` AND NOT `blank_n`. `inv_sync_flag` = `inv_sync_en` AND NOT `blank_n` AND NOT `csync_n`. Both use the R2 latency.
- R9: With `sync_out_en`=1, `sync_out` equals `csync_n` with the R2 latency. With `sync_out_en`=0, it is 0.
- R10: No level exceeds 1120. Code 255 with sync and pedestal on gives exactly 1120, and code 0 gives black: 380.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| red_code | input | 8 | Red pixel code |
| grn_code | input | 8 | Green pixel code |
| blu_code | input | 8 | Blue pixel code |
| blank_n | input | 1 | Blanking, active low |
| csync_n | input | 1 | Composite sync, active low |
| sync_chan_en | input | 3 | Sync enable per channel: bit 2 red, 1 green, 0 blue |
| pedestal_en | input | 1 | Adds the 7.5 IRE set-up step to black |
| inv_blank_en | input | 1 | Allows blanking onto the inverted outputs |
| inv_sync_en | input | 1 | Allows sync onto the inverted outputs |
| sync_out_en | input | 1 | Routes delayed composite sync to `sync_out` |
| red_lvl | output | 11 | Red level code in 1/8 IRE |
| grn_lvl | output | 11 | Green level code in 1/8 IRE |
| blu_lvl | output | 11 | Blue level code in 1/8 IRE |
| inv_blank_flag | output | 1 | Show blanking on the inverted outputs |
| inv_sync_flag | output | 1 | Show sync on the inverted outputs |
| sync_out | output | 1 | Delayed composite sync |

## Verification
The hardest case to reach is sync-enable bits that differ between channels while blanking is active. At the sync tip, an enabled channel and a disabled one both read 0. The per-channel mapping only shows when sync is released inside the blanking interval: the enabled channel then rises to 320 while the others stay at 0. The stimulus therefore drives blanking first with sync low and then with sync high, under several sync-enable patterns. It also drives nonzero pixel codes during blanking, to show that those codes are discarded. A separate one-edge sample confirms that the outputs do not move before the second edge.

// File: rtl/venc_pkg.sv
package venc_pkg;
  localparam int NUM_CH = 3;
  localparam int CH_BLU = 0;
  localparam int CH_GRN = 1;
  localparam int CH_RED = 2;

  typedef struct packed {
    logic [NUM_CH-1:0] sync_en;
    logic              ped_en;
    logic              inv_blank_en;
    logic              inv_sync_en;
    logic              sync_out_en;
  } ctrl_t;

  typedef struct packed {
    logic blank_n;
    logic csync_n;
  } timing_t;
endpackage

// File: rtl/venc_in_stage.sv
module venc_in_stage
  import venc_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_CH-1:0][CODE_W-1:0]  code_i,
  input  timing_t                        tmg_i,
  input  ctrl_t                          ctrl_i,
  output logic [NUM_CH-1:0][CODE_W-1:0]  code_q,
  output timing_t                        tmg_q,
  output ctrl_t                          ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      tmg_q  <= '{blank_n: 1'b1, csync_n: 1'b1};
      ctrl_q <= '0;
    end else begin
      code_q <= code_i;
      tmg_q  <= tmg_i;
      ctrl_q <= ctrl_i;
    end
  end
endmodule

// File: rtl/venc_chan.sv
module venc_chan
  import venc_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int SYNC_STEP = 320,
  parameter int PED_STEP  = 60,
  parameter int SPAN      = 740,
  parameter int LVL_W     = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic              sync_en,
  input  logic              ped_en,
  input  timing_t           tmg,
  output logic [LVL_W-1:0]  lvl
);
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int LVL_MAX  = SYNC_STEP + PED_STEP + SPAN;

  logic [31:0]      prod;
  logic [LVL_W-1:0] base, black, scaled, nxt;

  always_comb begin
    prod   = 32'(code) * 32'(SPAN);
    scaled = LVL_W'(prod / 32'(CODE_MAX));
    base   = sync_en ? LVL_W'(SYNC_STEP) : '0;
    black  = base + (ped_en ? LVL_W'(PED_STEP) : '0);
    if (tmg.blank_n)
      nxt = black + scaled;
    else if (!tmg.csync_n && sync_en)
      nxt = '0;
    else
      nxt = base;
  end

  always_ff @(posedge clk) begin
    if (rst) lvl <= '0;
    else     lvl <= nxt;
  end

  assert_level_range_R10: assert property (@(posedge clk) disable iff (rst)
    32'(lvl) <= 32'(LVL_MAX));

  // R4/R5: during blanking the level never leaves the sync..blank band
  assert_blank_band_R4: assert property (@(posedge clk) disable iff (rst)
    !tmg.blank_n |=> 32'(lvl) <= 32'(SYNC_STEP));

  // R3: active video never drops below the channel's blanking level
  assert_video_floor_R3: assert property (@(posedge clk) disable iff (rst)
    (tmg.blank_n && sync_en) |=> 32'(lvl) >= 32'(SYNC_STEP));
endmodule

// File: rtl/venc_sync_out.sv
module venc_sync_out
  import venc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  timing_t tmg,
  input  ctrl_t   ctrl,
  output logic    inv_blank_flag,
  output logic    inv_sync_flag,
  output logic    sync_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      inv_blank_flag <= 1'b0;
      inv_sync_flag  <= 1'b0;
      sync_out       <= 1'b0;
    end else begin
      inv_blank_flag <= ctrl.inv_blank_en & ~tmg.blank_n;
      inv_sync_flag  <= ctrl.inv_sync_en & ~tmg.blank_n & ~tmg.csync_n;
      sync_out       <= ctrl.sync_out_en & tmg.csync_n;
    end
  end

  assert_syncout_off_R9: assert property (@(posedge clk) disable iff (rst)
    !ctrl.sync_out_en |=> !sync_out);

  // R6/R8: inverted sync only appears inside blanking
  assert_inv_sync_blank_R8: assert property (@(posedge clk) disable iff (rst)
    tmg.blank_n |=> !inv_sync_flag);
endmodule

// File: rtl/venc_level_encoder.sv
module venc_level_encoder
  import venc_pkg::*;
#(
  parameter  int CODE_W    = 8,
  parameter  int SYNC_STEP = 320,
  parameter  int PED_STEP  = 60,
  parameter  int SPAN      = 740,
  localparam int LVL_W     = $clog2(SYNC_STEP + PED_STEP + SPAN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] red_code,
  input  logic [CODE_W-1:0] grn_code,
  input  logic [CODE_W-1:0] blu_code,
  input  logic              blank_n,
  input  logic              csync_n,
  input  logic [2:0]        sync_chan_en,
  input  logic              pedestal_en,
  input  logic              inv_blank_en,
  input  logic              inv_sync_en,
  input  logic              sync_out_en,
  output logic [LVL_W-1:0]  red_lvl,
  output logic [LVL_W-1:0]  grn_lvl,
  output logic [LVL_W-1:0]  blu_lvl,
  output logic              inv_blank_flag,
  output logic              inv_sync_flag,
  output logic              sync_out
);
  logic [NUM_CH-1:0][CODE_W-1:0] code_in, code_q;
  logic [NUM_CH-1:0][LVL_W-1:0]  lvl;
  timing_t tmg_in, tmg_q;
  ctrl_t   ctrl_in, ctrl_q;

  always_comb begin
    code_in[CH_RED] = red_code;
    code_in[CH_GRN] = grn_code;
    code_in[CH_BLU] = blu_code;
    tmg_in  = '{blank_n: blank_n, csync_n: csync_n};
    ctrl_in = '{sync_en: sync_chan_en, ped_en: pedestal_en,
                inv_blank_en: inv_blank_en, inv_sync_en: inv_sync_en,
                sync_out_en: sync_out_en};
  end

  venc_in_stage #(.CODE_W(CODE_W)) u_in (
    .clk(clk), .rst(rst), .code_i(code_in), .tmg_i(tmg_in), .ctrl_i(ctrl_in),
    .code_q(code_q), .tmg_q(tmg_q), .ctrl_q(ctrl_q));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    venc_chan #(.CODE_W(CODE_W), .SYNC_STEP(SYNC_STEP), .PED_STEP(PED_STEP),
                .SPAN(SPAN), .LVL_W(LVL_W)) u_chan (
      .clk(clk), .rst(rst), .code(code_q[c]), .sync_en(ctrl_q.sync_en[c]),
      .ped_en(ctrl_q.ped_en), .tmg(tmg_q), .lvl(lvl[c]));
  end

  venc_sync_out u_sync (
    .clk(clk), .rst(rst), .tmg(tmg_q), .ctrl(ctrl_q),
    .inv_blank_flag(inv_blank_flag), .inv_sync_flag(inv_sync_flag),
    .sync_out(sync_out));

  assign red_lvl = lvl[CH_RED];
  assign grn_lvl = lvl[CH_GRN];
  assign blu_lvl = lvl[CH_BLU];

  // R7: a channel with sync disabled never reaches the enabled blanking level while blanked
  assert_chan_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (!blank_n && !sync_chan_en[CH_RED]) |=> ##1 (red_lvl == '0));
endmodule

// File: tb/venc_level_encoder_tb.sv
`timescale 1ns/1ps
module venc_level_encoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] red_code = '0, grn_code = '0, blu_code = '0;
  logic blank_n = 1'b1, csync_n = 1'b1;
  logic [2:0] sync_chan_en = '0;
  logic pedestal_en = 1'b0, inv_blank_en = 1'b0, inv_sync_en = 1'b0, sync_out_en = 1'b0;
  logic [10:0] red_lvl, grn_lvl, blu_lvl;
  logic inv_blank_flag, inv_sync_flag, sync_out;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  venc_level_encoder u_dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_lvl(int code, bit sen, bit ped, bit bn, bit sn);
    int base = sen ? 320 : 0;
    if (bn) return base + (ped ? 60 : 0) + (code * 740) / 255;
    if (!sn && sen) return 0;
    return base;
  endfunction

  task automatic apply(int r, int g, int b, bit bn, bit sn, bit [2:0] sen,
                       bit ped, bit ib, bit is, bit soe);
    @(negedge clk);
    red_code = 8'(r); grn_code = 8'(g); blu_code = 8'(b);
    blank_n = bn; csync_n = sn; sync_chan_en = sen; pedestal_en = ped;
    inv_blank_en = ib; inv_sync_en = is; sync_out_en = soe;
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic check_all(string req);
    chk(req, "red_lvl", int'(red_lvl),
        exp_lvl(int'(red_code), sync_chan_en[2], pedestal_en, blank_n, csync_n));
    chk(req, "grn_lvl", int'(grn_lvl),
        exp_lvl(int'(grn_code), sync_chan_en[1], pedestal_en, blank_n, csync_n));
    chk(req, "blu_lvl", int'(blu_lvl),
        exp_lvl(int'(blu_code), sync_chan_en[0], pedestal_en, blank_n, csync_n));
    chk(req, "inv_blank_flag", int'(inv_blank_flag), int'(inv_blank_en & ~blank_n));
    chk(req, "inv_sync_flag", int'(inv_sync_flag), int'(inv_sync_en & ~blank_n & ~csync_n));
    chk(req, "sync_out", int'(sync_out), int'(sync_out_en & csync_n));
  endtask

  task automatic t_reset_r1();
    rst = 1'b1;
    apply(200, 100, 50, 1, 1, 3'b111, 1, 1, 1, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "red_lvl in reset", int'(red_lvl), 0);
    chk("R1", "grn_lvl in reset", int'(grn_lvl), 0);
    chk("R1", "blu_lvl in reset", int'(blu_lvl), 0);
    chk("R1", "sync_out in reset", int'(sync_out), 0);
    apply(0, 0, 0, 1, 1, 3'b000, 0, 0, 0, 0);
    rst = 1'b0;
    settle();
    check_all("R1");
  endtask

  task automatic t_video_r3();
    apply(0, 128, 255, 1, 1, 3'b111, 1, 0, 0, 0); settle(); check_all("R3");
    chk("R10", "white red=0 black", int'(red_lvl), 380);
    chk("R10", "white blue=255", int'(blu_lvl), 1120);
    apply(10, 77, 254, 1, 1, 3'b000, 0, 0, 0, 0); settle(); check_all("R3");
    apply(255, 1, 33, 1, 1, 3'b000, 1, 0, 0, 0); settle(); check_all("R3");
    chk("R3", "no-sync pedestal black", int'(grn_lvl), 62);
  endtask

  task automatic t_blank_r4();
    apply(255, 90, 3, 0, 1, 3'b111, 1, 0, 0, 0); settle(); check_all("R4");
    chk("R4", "blank level green", int'(grn_lvl), 320);
    apply(255, 90, 3, 0, 0, 3'b000, 1, 0, 0, 0); settle(); check_all("R4");
  endtask

  task automatic t_sync_r5();
    apply(255, 255, 255, 0, 0, 3'b111, 1, 0, 0, 0); settle(); check_all("R5");
    chk("R5", "sync tip red", int'(red_lvl), 0);
  endtask

  task automatic t_sync_video_r6();
    apply(40, 160, 220, 1, 0, 3'b111, 1, 1, 1, 0); settle(); check_all("R6");
    chk("R6", "inv_sync stays low in video", int'(inv_sync_flag), 0);
  endtask

  task automatic t_chan_r7();
    for (int m = 0; m < 8; m++) begin
      apply(9, 9, 9, 0, 1, 3'(m), 0, 0, 0, 0); settle(); check_all("R7");
      apply(9, 9, 9, 0, 0, 3'(m), 0, 0, 0, 0); settle(); check_all("R7");
    end
    apply(0, 0, 0, 0, 1, 3'b100, 0, 0, 0, 0); settle();
    chk("R7", "red only enabled red", int'(red_lvl), 320);
    chk("R7", "red only enabled green", int'(grn_lvl), 0);
  endtask

  task automatic t_flags_r8();
    apply(0, 0, 0, 0, 0, 3'b111, 0, 1, 0, 0); settle(); check_all("R8");
    apply(0, 0, 0, 0, 0, 3'b111, 0, 0, 1, 0); settle(); check_all("R8");
    apply(0, 0, 0, 0, 1, 3'b111, 0, 1, 1, 0); settle(); check_all("R8");
  endtask

  task automatic t_syncout_r9();
    apply(0, 0, 0, 0, 1, 3'b000, 0, 0, 0, 1); settle(); check_all("R9");
    chk("R9", "sync_out follows high", int'(sync_out), 1);
    apply(0, 0, 0, 0, 0, 3'b000, 0, 0, 0, 1); settle(); check_all("R9");
    apply(0, 0, 0, 0, 1, 3'b000, 0, 0, 0, 0); settle(); check_all("R9");
    chk("R9", "sync_out disabled", int'(sync_out), 0);
  endtask

  task automatic t_latency_r2();
    apply(0, 0, 0, 1, 1, 3'b111, 0, 0, 0, 1); settle();
    apply(255, 255, 255, 0, 0, 3'b111, 0, 1, 1, 1);
    @(posedge clk); @(negedge clk);
    chk("R2", "red after one edge", int'(red_lvl), 320);
    chk("R2", "sync_out after one edge", int'(sync_out), 1);
    chk("R2", "inv_blank after one edge", int'(inv_blank_flag), 0);
    @(posedge clk); @(negedge clk);
    check_all("R2");
  endtask

  initial begin
    t_reset_r1();
    t_video_r3();
    t_blank_r4();
    t_sync_r5();
    t_sync_video_r6();
    t_chan_r7();
    t_flags_r8();
    t_syncout_r9();
    t_latency_r2();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule